// File: doc/BRIEF.md
# Write-Completion Acknowledge Poller

After a host writes to a serial EEPROM, the device spends up to 4 ms on its internal write cycle. During that time it does not acknowledge its select byte. This block sits on the host side of the two-wire bus and finds out when the device is free again. It does not handle bus bits itself. Instead, it sends commands to a byte-level host engine. The commands are "generate Start", "send this byte and report the acknowledge" and "generate Stop".

On a go strobe, the block captures the 7-bit device address and the read/write intent and forms the select byte from them. It then repeats a cycle of Start followed by that select byte. The cycle continues until the device acknowledges. At that point the block raises ready and sends no Stop. The bus stays claimed, and the acknowledged select byte counts as the first byte of the instruction that comes next.

Each refused select counts as one poll. The number of polls is capped by a parameter. The parameter should be sized so that the polls cover the 4 ms worst-case write time. When the last allowed poll is also refused, the block sends a Stop to release the bus and raises timeout.

Top module: `ackp_poller`

## Requirements
- R1: After reset, cmd_valid, ready and timeout are all 0.
- R2: When go is sampled high while the block is idle, cmd_valid is high for that one cycle with cmd_op = 0 (Start) at the clock edge that samples go. ready and timeout are cleared at the same edge.
- R3: The clock edge that samples eng_done for a Start command issues a send-byte command (cmd_op = 1). Its cmd_byte is {dev_addr, rw}, with the address in bits 7:1 and rw in bit 0, both captured at the edge that accepted go.
- R4: If a select byte is refused (eng_done with eng_ack = 0) and fewer than MAX_POLLS selects have been refused, the next command is another Start (cmd_op = 0), not a Stop.
- R5: If a select byte is acknowledged (eng_done with eng_ack = 1), ready rises at that edge and no further command is issued, not even a Stop.
- R6: If MAX_POLLS selects in a row are refused, a Stop command (cmd_op = 2) follows. At the edge that samples its eng_done, timeout rises and ready stays 0. If the select at poll number MAX_POLLS is acknowledged, the result is ready, not timeout.
- R7: ready and timeout keep their value until the next accepted go.
- R8: go is ignored while a poll sequence is running, and a change of dev_addr or rw after acceptance does not alter the select byte.
- R9: eng_done while the block is idle issues no command and changes neither ready nor timeout.
- R10: cmd_valid lasts one cycle, and no new command is issued until the engine has reported eng_done for the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start a poll sequence (one-cycle strobe) |
| dev_addr | input | 7 | Device address for the select byte |
| rw | input | 1 | Read/write intent placed in bit 0 of the select byte |
| eng_done | input | 1 | Engine finished the current command (one-cycle pulse) |
| eng_ack | input | 1 | Acknowledge seen for a sent byte, valid with eng_done |
| cmd_valid | output | 1 | One-cycle command request to the engine |
| cmd_op | output | 2 | Command: 0 Start, 1 send byte, 2 Stop |
| cmd_byte | output | 8 | Byte to send with a send-byte command |
| ready | output | 1 | Device acknowledged its select; bus still held |
| timeout | output | 1 | Poll limit exhausted; bus released with Stop |

## Verification
Every command request is registered. It therefore becomes visible one edge after the edge that samples go, or the eng_done of the previous command. The bench drives inputs and samples outputs on falling edges, so each request is checked at the first falling edge after its cause. The queue of expected commands must hold exactly the next request when it appears. ready and timeout are due at the edge that samples the closing eng_done. The bench checks them after the sequence and again several cycles later, to confirm that they hold.

// File: rtl/ackp_pkg.sv
package ackp_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_STOP  = 2'd2
  } ackp_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WSTRT = 2'd1,
    ST_WSEL  = 2'd2,
    ST_WSTOP = 2'd3
  } ackp_state_e;
endpackage

// File: rtl/ackp_poll_count.sv
module ackp_poll_count #(
  parameter int MAX_POLLS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam logic [CW-1:0] LAST_VAL = CW'(MAX_POLLS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (inc && cnt_q != LAST_VAL) cnt_q <= cnt_q + 1'b1;
  end

  assign last = (cnt_q == LAST_VAL);
endmodule

// File: rtl/ackp_seq.sv
module ackp_seq
  import ackp_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     go,
  input  logic     eng_done,
  input  logic     eng_ack,
  input  logic     poll_last,
  output logic     issue,
  output ackp_op_e issue_op,
  output logic     capture,
  output logic     cnt_clr,
  output logic     cnt_inc,
  output logic     set_ready,
  output logic     set_timeout
);
  ackp_state_e st_q, st_d;

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  always_comb begin
    st_d        = st_q;
    issue       = 1'b0;
    issue_op    = OP_START;
    capture     = 1'b0;
    cnt_clr     = 1'b0;
    cnt_inc     = 1'b0;
    set_ready   = 1'b0;
    set_timeout = 1'b0;
    unique case (st_q)
      ST_IDLE: if (go) begin
        st_d    = ST_WSTRT;
        issue   = 1'b1;
        capture = 1'b1;
        cnt_clr = 1'b1;
      end
      ST_WSTRT: if (eng_done) begin
        st_d     = ST_WSEL;
        issue    = 1'b1;
        issue_op = OP_WRITE;
      end
      ST_WSEL: if (eng_done) begin
        if (eng_ack) begin
          st_d      = ST_IDLE;
          set_ready = 1'b1;
        end else if (poll_last) begin
          st_d     = ST_WSTOP;
          issue    = 1'b1;
          issue_op = OP_STOP;
        end else begin
          st_d    = ST_WSTRT;
          issue   = 1'b1;
          cnt_inc = 1'b1;
        end
      end
      ST_WSTOP: if (eng_done) begin
        st_d        = ST_IDLE;
        set_timeout = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/ackp_out_reg.sv
module ackp_out_reg
  import ackp_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              rw,
  input  logic              issue,
  input  ackp_op_e          issue_op,
  input  logic              set_ready,
  input  logic              set_timeout,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [ADDR_W:0]   cmd_byte,
  output logic              ready,
  output logic              timeout
);
  logic [ADDR_W:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= '0;
      cmd_valid <= 1'b0;
      cmd_op    <= OP_START;
      cmd_byte  <= '0;
      ready     <= 1'b0;
      timeout   <= 1'b0;
    end else begin
      cmd_valid <= issue;
      if (capture) begin
        sel_q   <= {dev_addr, rw};
        ready   <= 1'b0;
        timeout <= 1'b0;
      end
      if (issue) begin
        cmd_op <= issue_op;
        if (issue_op == OP_WRITE) cmd_byte <= sel_q;
      end
      if (set_ready)   ready   <= 1'b1;
      if (set_timeout) timeout <= 1'b1;
    end
  end
endmodule

// File: rtl/ackp_poller.sv
module ackp_poller
  import ackp_pkg::*;
#(
  parameter int MAX_POLLS = 64,
  parameter int ADDR_W    = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              rw,
  input  logic              eng_done,
  input  logic              eng_ack,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [ADDR_W:0]   cmd_byte,
  output logic              ready,
  output logic              timeout
);
  logic     issue, capture, cnt_clr, cnt_inc, set_ready, set_timeout, poll_last;
  ackp_op_e issue_op;

  ackp_poll_count #(.MAX_POLLS(MAX_POLLS)) u_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc), .last(poll_last)
  );

  ackp_seq u_seq (
    .clk(clk), .rst(rst), .go(go), .eng_done(eng_done), .eng_ack(eng_ack),
    .poll_last(poll_last), .issue(issue), .issue_op(issue_op),
    .capture(capture), .cnt_clr(cnt_clr), .cnt_inc(cnt_inc),
    .set_ready(set_ready), .set_timeout(set_timeout)
  );

  ackp_out_reg #(.ADDR_W(ADDR_W)) u_out (
    .clk(clk), .rst(rst), .capture(capture), .dev_addr(dev_addr), .rw(rw),
    .issue(issue), .issue_op(issue_op), .set_ready(set_ready),
    .set_timeout(set_timeout), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .ready(ready), .timeout(timeout)
  );
endmodule

// File: rtl/ackp_poller_chk.sv
module ackp_poller_chk (
  input logic       clk,
  input logic       rst,
  input logic       eng_done,
  input logic       eng_ack,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       ready,
  input logic       timeout
);
  // R10: requests are single-cycle pulses
  assert_cmd_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  // R5: once ready, no command is being requested
  assert_ready_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    ready |-> !cmd_valid);

  // R5: ready only rises after an acknowledged engine completion
  assert_ready_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(eng_done && eng_ack));

  // R6: timeout only rises after an engine completion, never with ready
  assert_timeout_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout) |-> ($past(eng_done) && !ready));

  // R6: a Stop request is never followed by ready
  assert_stop_no_ready_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd2) |=> !ready);
endmodule

bind ackp_poller ackp_poller_chk u_chk (
  .clk(clk), .rst(rst), .eng_done(eng_done), .eng_ack(eng_ack),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op), .ready(ready), .timeout(timeout)
);

// File: tb/test_ackp_poller.sv
`timescale 1ns/1ps
module test_ackp_poller;
  localparam int MAXP = 4;
  localparam int LAT  = 3;

  logic clk = 0, rst = 1, go = 0, rw = 0, eng_done = 0, eng_ack = 0;
  logic [6:0] dev_addr = '0;
  logic cmd_valid, ready, timeout;
  logic [1:0] cmd_op;
  logic [7:0] cmd_byte;

  always #5 clk = ~clk;

  ackp_poller #(.MAX_POLLS(MAXP)) i_ackp_poller (
    .clk(clk), .rst(rst), .go(go), .dev_addr(dev_addr), .rw(rw),
    .eng_done(eng_done), .eng_ack(eng_ack), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_byte(cmd_byte), .ready(ready), .timeout(timeout)
  );

  int checks = 0, failures = 0;
  logic [9:0] exp_q[$];   // {op, byte}
  int nack_left = 0;
  bit pend = 0, pend_ack = 0, stray = 0, finished = 0;
  int wait_cnt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // engine model and scoreboard monitor
  always @(negedge clk) begin
    eng_done = 0;
    if (stray) begin eng_done = 1; eng_ack = 1; stray = 0; end
    if (cmd_valid) begin
      chk(!pend, "R10 command while previous outstanding", 1, 0);
      if (exp_q.size() == 0) begin
        chk(0, "R5/R9 unexpected command", {cmd_op, cmd_byte}, 0);
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        if (e[9:8] == 2'd1)
          chk({cmd_op, cmd_byte} == e, "R3 send-select command", {cmd_op, cmd_byte}, e);
        else if (e[9:8] == 2'd2)
          chk(cmd_op == e[9:8], "R6 stop command", cmd_op, e[9:8]);
        else
          chk(cmd_op == e[9:8], "R2/R4 start command", cmd_op, e[9:8]);
      end
      pend = 1;
      wait_cnt = LAT;
      if (cmd_op == 2'd1 && nack_left > 0) begin pend_ack = 0; nack_left--; end
      else pend_ack = 1;
    end else if (pend) begin
      if (wait_cnt == 0) begin eng_done = 1; eng_ack = pend_ack; pend = 0; end
      else wait_cnt--;
    end
  end

  task automatic run_seq(input logic [6:0] a, input logic r, input int nacks,
                         input bit disturb);
    int polls;
    bit to;
    to = (nacks >= MAXP);
    polls = to ? MAXP : nacks + 1;
    for (int i = 0; i < polls; i++) begin
      exp_q.push_back({2'd0, 8'h00});
      exp_q.push_back({2'd1, a, r});
    end
    if (to) exp_q.push_back({2'd2, 8'h00});
    nack_left = nacks;
    @(negedge clk);
    dev_addr = a; rw = r; go = 1;
    @(negedge clk);
    go = 0;
    chk(ready == 0 && timeout == 0, "R2 flags cleared on go", {ready, timeout}, 0);
    if (disturb) begin
      repeat (2) @(negedge clk);
      dev_addr = ~a; rw = ~r; go = 1;   // R8 ignored while running
      @(negedge clk);
      go = 0;
    end
    for (int k = 0; k < 2000 && !(ready || timeout); k++) @(negedge clk);
    repeat (8) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all expected commands seen", exp_q.size(), 0);
    if (to) chk(timeout == 1 && ready == 0, "R6 timeout after limit", {ready, timeout}, 1);
    else    chk(ready == 1 && timeout == 0, "R5 ready on acknowledge", {ready, timeout}, 2);
    repeat (5) @(negedge clk);
    chk(ready == !to && timeout == to, "R7 flags hold", {ready, timeout}, {!to, to});
    exp_q.delete();
    nack_left = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(cmd_valid == 0 && ready == 0 && timeout == 0, "R1 reset state",
        {cmd_valid, ready, timeout}, 0);
    run_seq(7'h50, 1'b0, 0, 0);           // R5 immediate acknowledge
    run_seq(7'h2A, 1'b1, 2, 0);           // R4 retries then ready
    run_seq(7'h13, 1'b0, MAXP - 1, 0);    // R6 boundary: last poll acknowledged
    run_seq(7'h7F, 1'b1, 10, 0);          // R6 limit exceeded
    run_seq(7'h41, 1'b1, 1, 1);           // R8 disturbance ignored
    // R9 stray completion while idle
    stray = 1;
    repeat (6) @(negedge clk);
    chk(cmd_valid == 0 && ready == 1 && timeout == 0, "R9 idle done ignored",
        {cmd_valid, ready, timeout}, 2);
    run_seq(7'h00, 1'b0, 10, 0);          // R6 timeout again, R7 ready cleared
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule